// File: doc/BRIEF.md
# RTC Interrupt Control and Status

This block is the interrupt section of a real-time clock that keeps a legacy register layout. Software reaches three byte-wide registers through an indexed read/write bus. The control byte holds three interrupt enables and a set-mode bit. The status byte holds three event flags, which clear when the byte is read, and a combined request bit. The validity byte reports whether the supply dropped too low since it was last read.

The rest of the clock sends the block three inputs. One strobe marks the end of each time update. A second strobe marks each toggle of the selected divider tap. A level input is high when the current time equals the alarm time. The block drives an active-low interrupt request. While set mode is on, it holds the user-visible time copy still: it raises a freeze output and suppresses the strobe that would refresh that copy. A low-supply level input is caught in a sticky latch.

There are two kinds of reset. The asynchronous power-on reset clears every register. The synchronous master reset clears the enables and the flags, but it leaves the set-mode bit and the supply latch as they are.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After power-on reset, index 0x0B, 0x0C and 0x0D all read 0x00, and irqN is 1.
- R2: A write to index 0x0B stores bit 7 as set mode, bit 6 as the periodic enable, bit 5 as the alarm enable and bit 4 as the update enable. Bits 3 to 0 always read 0.
- R3: A master reset pulse clears bits 6 to 4 of index 0x0B and leaves bit 7 unchanged.
- R4: While set mode is 1, freezeUser is 1 and userUpdStb stays 0. While set mode is 0, userUpdStb follows updStb in the same cycle.
- R5: updStb and perStb set the update flag (bit 4) and the periodic flag (bit 6) of index 0x0C whatever the enables hold. The flag is visible on the first read after the strobe's clock edge. Bits 3 to 0 of 0x0C always read 0.
- R6: The alarm flag (bit 5 of 0x0C) is set only by an update strobe that arrives while almMatch is 1.
- R7: A read of 0x0C returns the current flags and clears them. An event in the same cycle as the read is not in the returned value, and its flag stays set afterwards.
- R8: Bit 7 of 0x0C is 1 exactly when some enable and its matching flag are both 1, and it is always the inverse of irqN. irqN goes low at the clock edge where such a pair first forms.
- R9: irqN returns to 1 at the clock edge of the read of 0x0C that clears the last enabled pair.
- R10: A master reset pulse clears all three flags in 0x0C.
- R11: Index 0x0D reads only bit 7, the valid bit; bits 6 to 0 read 0. Any cycle with lowSupply high makes the valid bit read 0. A read of 0x0D sets the valid bit back to 1, unless lowSupply is high during that read.
- R12: Writes to 0x0C and 0x0D change nothing, and any other index reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| masterRst | input | 1 | Synchronous master reset; clears the enables and the flags |
| busIdx | input | 8 | Register index |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe; clear-on-read side effects happen at its clock edge |
| busWData | input | 8 | Write data |
| rData | output | 8 | Read data; combinational from the index |
| updStb | input | 1 | Strobe marking the end of a time update |
| almMatch | input | 1 | High while the time equals the alarm time |
| perStb | input | 1 | Strobe marking a divider tap toggle |
| lowSupply | input | 1 | High while the supply is too low |
| irqN | output | 1 | Registered interrupt request, active low |
| freezeUser | output | 1 | High while the user time copy is held |
| userUpdStb | output | 1 | Refresh strobe for the user time copy |

## Verification
rData, freezeUser and userUpdStb are combinational. The bench samples them 1 ns after it drives the inputs at a falling edge, before the next rising edge commits any change. Flags, enables, the supply latch and irqN change at the rising edge that takes the strobe, so the bench checks irqN, and reads back the state, no earlier than the falling edge after that rising edge. For a read that races an event, the bench samples the returned byte inside the read cycle. It checks irqN and the re-read byte in later cycles.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W = 8;
  localparam int N_EV = 3;
  localparam int EV_LO = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_STS  = 2'd2,
    SEL_VLD  = 2'd3
  } regSel_t;

  typedef struct packed {
    logic    wrCtl;
    logic    rdSts;
    logic    rdVld;
    regSel_t sel;
  } busStrb_t;
endpackage

// File: rtl/rtc_irq_decode.sv
module rtc_irq_decode
  import rtc_irq_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] IDX_CTL = 'h0B,
  parameter logic [IDX_W-1:0] IDX_STS = 'h0C,
  parameter logic [IDX_W-1:0] IDX_VLD = 'h0D
) (
  input  logic [IDX_W-1:0] busIdx,
  input  logic             busWr,
  input  logic             busRd,
  output busStrb_t         strb
);
  always_comb begin
    strb.sel = SEL_NONE;
    if (busIdx == IDX_CTL)      strb.sel = SEL_CTL;
    else if (busIdx == IDX_STS) strb.sel = SEL_STS;
    else if (busIdx == IDX_VLD) strb.sel = SEL_VLD;
    strb.wrCtl = busWr && (strb.sel == SEL_CTL);
    strb.rdSts = busRd && (strb.sel == SEL_STS);
    strb.rdVld = busRd && (strb.sel == SEL_VLD);
  end
endmodule

// File: rtl/rtc_irq_dp.sv
module rtc_irq_dp
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterRst,
  input  busStrb_t          strb,
  input  logic [DATA_W-1:0] wData,
  input  logic              updStb,
  input  logic              almMatch,
  input  logic              perStb,
  input  logic              lowSupply,
  output logic [DATA_W-1:0] rData,
  output logic              irqN,
  output logic              freezeUser,
  output logic              userUpdStb
);
  // Event order matches the flag and enable bit order: update, alarm, periodic.
  logic [N_EV-1:0] evt;
  logic [N_EV-1:0] flagQ, flagNext;
  logic [N_EV-1:0] enQ, enNext;
  logic            setQ, setNext;
  logic            lowQ, lowNext;
  logic            irqNext, irqNow;

  assign evt = {perStb, updStb && almMatch, updStb};

  genvar g;
  generate
    for (g = 0; g < N_EV; g++) begin : gFlag
      always_comb begin
        if (masterRst) flagNext[g] = 1'b0;
        else           flagNext[g] = (flagQ[g] && !strb.rdSts) || evt[g];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) flagQ[g] <= 1'b0;
        else       flagQ[g] <= flagNext[g];
      end
    end
  endgenerate

  always_comb begin
    if (masterRst)       enNext = '0;
    else if (strb.wrCtl) enNext = wData[EV_LO +: N_EV];
    else                 enNext = enQ;
    setNext = strb.wrCtl ? wData[DATA_W-1] : setQ;
    lowNext = (lowQ && !strb.rdVld) || lowSupply;
    irqNext = |(enNext & flagNext);
    irqNow  = |(enQ & flagQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= '0;
      setQ <= 1'b0;
      lowQ <= 1'b1;
      irqN <= 1'b1;
    end else begin
      enQ  <= enNext;
      setQ <= setNext;
      lowQ <= lowNext;
      irqN <= !irqNext;
    end
  end

  always_comb begin
    rData = '0;
    case (strb.sel)
      SEL_CTL: begin
        rData[DATA_W-1]        = setQ;
        rData[EV_LO +: N_EV]   = enQ;
      end
      SEL_STS: begin
        rData[DATA_W-1]        = irqNow;
        rData[EV_LO +: N_EV]   = flagQ;
      end
      SEL_VLD: rData[DATA_W-1] = !lowQ;
      default: rData = '0;
    endcase
  end

  assign freezeUser = setQ;
  assign userUpdStb = updStb && !setQ;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] IDX_CTL = 'h0B,
  parameter logic [IDX_W-1:0] IDX_STS = 'h0C,
  parameter logic [IDX_W-1:0] IDX_VLD = 'h0D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterRst,
  input  logic [IDX_W-1:0]  busIdx,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] rData,
  input  logic              updStb,
  input  logic              almMatch,
  input  logic              perStb,
  input  logic              lowSupply,
  output logic              irqN,
  output logic              freezeUser,
  output logic              userUpdStb
);
  busStrb_t strb;

  rtc_irq_decode #(
    .IDX_W(IDX_W), .IDX_CTL(IDX_CTL), .IDX_STS(IDX_STS), .IDX_VLD(IDX_VLD)
  ) u_dec (
    .busIdx(busIdx), .busWr(busWr), .busRd(busRd), .strb(strb)
  );

  rtc_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .strb(strb),
    .wData(busWData), .updStb(updStb), .almMatch(almMatch), .perStb(perStb),
    .lowSupply(lowSupply), .rData(rData), .irqN(irqN),
    .freezeUser(freezeUser), .userUpdStb(userUpdStb)
  );
endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk #(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] IDX_STS = 'h0C,
  parameter logic [IDX_W-1:0] IDX_VLD = 'h0D
) (
  input logic             clk,
  input logic             rstN,
  input logic             masterRst,
  input logic [IDX_W-1:0] busIdx,
  input logic             busWr,
  input logic             busRd,
  input logic             updStb,
  input logic             almMatch,
  input logic             perStb,
  input logic             lowSupply,
  input logic             irqN,
  input logic             freezeUser,
  input logic             userUpdStb,
  input logic [2:0]       enQ,
  input logic [2:0]       flagQ,
  input logic             setQ,
  input logic             lowQ
);
  AST_MRST_KEEPS_SET: assert property (@(posedge clk) disable iff (!rstN)
    masterRst && !busWr |=> enQ == 3'b000 && setQ == $past(setQ)); // R3
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    setQ |-> freezeUser && !userUpdStb); // R4
  AST_UPDATE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    updStb && !masterRst |=> flagQ[0]); // R5
  AST_ALARM_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[1]) |-> $past(updStb && almMatch)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    busRd && busIdx == IDX_STS && !updStb && !perStb |=> flagQ == 3'b000 && irqN); // R9
  AST_IRQ_TRACKS_PAIRS: assert property (@(posedge clk) disable iff (!rstN)
    irqN == !(|(enQ & flagQ))); // R8
  AST_MRST_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    masterRst |=> flagQ == 3'b000); // R10
  AST_LOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lowSupply |=> lowQ); // R11
  AST_IGNORED_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    busWr && !busRd && (busIdx == IDX_STS || busIdx == IDX_VLD) && !masterRst
      && !updStb && !perStb |=> $stable(flagQ) && $stable(enQ) && $stable(setQ)); // R12
endmodule

bind rtc_irq_ctrl rtc_irq_chk #(
  .IDX_W(IDX_W), .IDX_STS(IDX_STS), .IDX_VLD(IDX_VLD)
) u_chk (
  .clk(clk), .rstN(rstN), .masterRst(masterRst), .busIdx(busIdx),
  .busWr(busWr), .busRd(busRd), .updStb(updStb), .almMatch(almMatch),
  .perStb(perStb), .lowSupply(lowSupply), .irqN(irqN),
  .freezeUser(freezeUser), .userUpdStb(userUpdStb),
  .enQ(u_dp.enQ), .flagQ(u_dp.flagQ), .setQ(u_dp.setQ), .lowQ(u_dp.lowQ)
);

// File: tb/sim_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_rtc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterRst = 1'b0;
  logic [7:0] busIdx = 8'h00;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWData = 8'h00;
  logic [7:0] rData;
  logic       updStb = 1'b0;
  logic       almMatch = 1'b0;
  logic       perStb = 1'b0;
  logic       lowSupply = 1'b0;
  logic       irqN, freezeUser, userUpdStb;
  int         nChk = 0;
  int         nFail = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  rtc_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .busIdx(busIdx),
    .busWr(busWr), .busRd(busRd), .busWData(busWData), .rData(rData),
    .updStb(updStb), .almMatch(almMatch), .perStb(perStb),
    .lowSupply(lowSupply), .irqN(irqN), .freezeUser(freezeUser),
    .userUpdStb(userUpdStb)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); busIdx = idx; busWData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic [7:0] v);
    @(negedge clk); busIdx = idx; busRd = 1'b1;
    #1 v = rData;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic pulse(input bit u, input bit m, input bit p);
    @(negedge clk); updStb = u; almMatch = m; perStb = p;
    @(negedge clk); updStb = 1'b0; almMatch = 1'b0; perStb = 1'b0;
  endtask

  task automatic mrst();
    @(negedge clk); masterRst = 1'b1;
    @(negedge clk); masterRst = 1'b0;
  endtask

  task automatic tReset();
    logic [7:0] v;
    check("R1 irqN", {7'b0, irqN}, 8'h01);
    rdReg(8'h0B, v); check("R1 ctl", v, 8'h00);
    rdReg(8'h0C, v); check("R1 sts", v, 8'h00);
    rdReg(8'h0D, v); check("R1 vld", v, 8'h00);
  endtask

  task automatic tCtl();
    logic [7:0] v;
    wrReg(8'h0B, 8'hFF); rdReg(8'h0B, v); check("R2 all ones", v, 8'hF0);
    wrReg(8'h0B, 8'h50); rdReg(8'h0B, v); check("R2 pattern", v, 8'h50);
    wrReg(8'h0B, 8'hF0); mrst(); rdReg(8'h0B, v); check("R3 set kept", v, 8'h80);
    wrReg(8'h0B, 8'h30); mrst(); rdReg(8'h0B, v); check("R3 set zero", v, 8'h00);
  endtask

  task automatic tFreeze();
    logic [7:0] v;
    wrReg(8'h0B, 8'h80);
    @(negedge clk); updStb = 1'b1;
    #1 check("R4 frozen strobe", {6'b0, freezeUser, userUpdStb}, 8'h02);
    @(negedge clk); updStb = 1'b0;
    wrReg(8'h0B, 8'h00);
    @(negedge clk); updStb = 1'b1;
    #1 check("R4 live strobe", {6'b0, freezeUser, userUpdStb}, 8'h01);
    @(negedge clk); updStb = 1'b0;
    rdReg(8'h0C, v);
  endtask

  task automatic tFlags();
    logic [7:0] v;
    pulse(1'b0, 1'b0, 1'b1);
    check("R5 no irq disabled", {7'b0, irqN}, 8'h01);
    rdReg(8'h0C, v); check("R5 periodic", v, 8'h40);
    rdReg(8'h0C, v); check("R7 cleared", v, 8'h00);
    pulse(1'b1, 1'b0, 1'b0);
    rdReg(8'h0C, v); check("R6 no match", v, 8'h10);
    pulse(1'b1, 1'b1, 1'b0);
    rdReg(8'h0C, v); check("R6 match", v, 8'h30);
    pulse(1'b0, 1'b1, 1'b0);
    rdReg(8'h0C, v); check("R6 match alone", v, 8'h00);
  endtask

  task automatic tIrq();
    logic [7:0] v;
    wrReg(8'h0B, 8'h10);
    pulse(1'b1, 1'b0, 1'b0);
    check("R8 irq low", {7'b0, irqN}, 8'h00);
    rdReg(8'h0C, v); check("R8 request bit", v, 8'h90);
    check("R9 irq released", {7'b0, irqN}, 8'h01);
    wrReg(8'h0B, 8'h40);
    pulse(1'b1, 1'b1, 1'b0);
    check("R8 unpaired flags", {7'b0, irqN}, 8'h01);
    rdReg(8'h0C, v); check("R8 no request", v, 8'h30);
  endtask

  task automatic tRace();
    logic [7:0] v;
    wrReg(8'h0B, 8'h10);
    @(negedge clk); busIdx = 8'h0C; busRd = 1'b1; updStb = 1'b1;
    #1 v = rData;
    @(negedge clk); busRd = 1'b0; updStb = 1'b0;
    check("R7 race old value", v, 8'h00);
    check("R7 race irq", {7'b0, irqN}, 8'h00);
    rdReg(8'h0C, v); check("R7 race kept", v, 8'h90);
    wrReg(8'h0B, 8'h00);
  endtask

  task automatic tMrstFlags();
    logic [7:0] v;
    pulse(1'b1, 1'b1, 1'b1);
    mrst();
    rdReg(8'h0C, v); check("R10 flags cleared", v, 8'h00);
  endtask

  task automatic tValid();
    logic [7:0] v;
    rdReg(8'h0D, v); check("R11 valid after read", v, 8'h80);
    @(negedge clk); lowSupply = 1'b1;
    @(negedge clk); lowSupply = 1'b0;
    rdReg(8'h0D, v); check("R11 low seen", v, 8'h00);
    rdReg(8'h0D, v); check("R11 restored", v, 8'h80);
    mrst();
    rdReg(8'h0D, v); check("R11 mrst keeps", v, 8'h80);
  endtask

  task automatic tIgnore();
    logic [7:0] v;
    wrReg(8'h0B, 8'h70);
    wrReg(8'h0C, 8'hFF);
    check("R12 sts write irq", {7'b0, irqN}, 8'h01);
    rdReg(8'h0C, v); check("R12 sts write", v, 8'h00);
    wrReg(8'h0D, 8'h00);
    rdReg(8'h0D, v); check("R12 vld write", v, 8'h80);
    rdReg(8'h0B, v); check("R12 ctl intact", v, 8'h70);
    rdReg(8'h0E, v); check("R12 other index", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCtl();
    tFreeze();
    tFlags();
    tIrq();
    tRace();
    tMrstFlags();
    tValid();
    tIgnore();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule